// File: doc/BRIEF.md
# Component Video Word Demultiplexer

This block receives a multiplexed component video stream, one 10-bit word per clock, and separates it into three parallel channels: luma (Y), blue-difference chroma (Cb) and red-difference chroma (Cr). The stream repeats the pattern Cb, Y, Cr, Y. The first three words of each group are cosited and are presented together as a triple. The fourth word is a lone luma sample and is presented on its own output.

A four-step word-phase counter tracks the position within the group. The counter is aligned by a control pulse: `sync_i` high in one cycle, then low in the next, marks the word present in that second cycle as a Cb word. After alignment the control may stay low for as long as needed, or it may pulse once per group. Words are not inspected. Ancillary and timing-reference words pass through exactly like picture samples. Data with 8-bit precision is carried on bits 9..2 with bits 1..0 at zero, and it is treated as an ordinary 10-bit word.

The outputs are single-cycle valid strobes with no ready input. The source delivers one word on every clock and cannot be stalled, so back-pressure is not supported. The sink must take every strobe in the cycle it is asserted. The data outputs keep their last value between strobes.

Top module: `vdmx`

## Requirements
- R1: While `rst_n` is low, both strobes are low and all four data outputs are zero.
- R2: No strobe is asserted until the first alignment event, where `sync_i` is sampled high and then low in the next cycle. Holding `sync_i` constant at either level never aligns.
- R3: The word present in an alignment cycle is taken as Cb (phase 0). The following words are taken as Y (phase 1), Cr (phase 2) and the lone Y (phase 3), in that order.
- R4: `trip_valid_o` is high for exactly one cycle: the cycle after the Cr word. In that cycle `trip_cb_o`, `trip_y_o` and `trip_cr_o` carry the phase 0, 1 and 2 words of that group.
- R5: `solo_valid_o` is high for one cycle after the phase 3 word, with that word on `solo_y_o`. It follows the triple strobe by one cycle unless an alignment event falls on the phase 3 word.
- R6: With `sync_i` held low after alignment, the pattern of one triple and one lone luma sample repeats every four words.
- R7: An alignment event that falls on a word already in phase 0 leaves the sequence and the outputs unchanged.
- R8: An alignment event on a word in any other phase restarts the count at Cb with that word. No triple is emitted for the group that was interrupted.
- R9: Every word value reaches the outputs bit for bit, including 10'h000, 10'h3FF and 8-bit data with bits 1..0 at zero.
- R10: The two strobes are never high in the same cycle.
- R11: The data outputs change only in a cycle in which their strobe is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| sync_i | input | 1 | Alignment control: high then low marks a Cb word |
| word_i | input | 10 | Multiplexed input word |
| trip_valid_o | output | 1 | One-cycle strobe for the cosited triple |
| trip_y_o | output | 10 | Cosited luma |
| trip_cb_o | output | 10 | Blue-difference chroma |
| trip_cr_o | output | 10 | Red-difference chroma |
| solo_valid_o | output | 1 | One-cycle strobe for the lone luma sample |
| solo_y_o | output | 10 | Lone luma sample |

## Verification
Take an alignment event in cycle N, so the Cb word is on the input in cycle N. The triple strobe and its data are then due in cycle N+3, one register after the Cr word in N+2. The lone luma strobe is due in N+4. The bench applies each word half a period before the edge that samples it and reads the outputs at the following falling edge, so every expected value belongs to the word just applied. Re-alignment checks read the strobe in the same cycle in which an interrupted triple would have appeared.

// File: rtl/vdmx_pkg.sv
package vdmx_pkg;
  localparam int NUM_PH = 4;
  localparam int PH_W   = $clog2(NUM_PH);

  typedef enum logic [PH_W-1:0] {
    PH_CB = 2'd0,
    PH_Y0 = 2'd1,
    PH_CR = 2'd2,
    PH_Y1 = 2'd3
  } phase_t;
endpackage

// File: rtl/vdmx_phase.sv
module vdmx_phase
  import vdmx_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   sync_i,
  output phase_t phase_o,
  output logic   live_o
);
  logic            sync_q;
  logic            locked_q;
  phase_t          ph_q;
  logic            align;
  logic [PH_W-1:0] ph_nxt;

  assign align   = sync_q & ~sync_i;
  assign phase_o = align ? PH_CB : ph_q;
  assign live_o  = locked_q | align;
  assign ph_nxt  = phase_o + 2'd1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q   <= 1'b0;
      locked_q <= 1'b0;
      ph_q     <= PH_CB;
    end else begin
      sync_q <= sync_i;
      ph_q   <= phase_t'(ph_nxt);
      if (align) locked_q <= 1'b1;
    end
  end
endmodule

// File: rtl/vdmx_capture.sv
module vdmx_capture
  import vdmx_pkg::*;
#(
  parameter int DW = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  phase_t        phase_i,
  input  logic          live_i,
  input  logic [DW-1:0] word_i,
  output logic          trip_valid_o,
  output logic [DW-1:0] trip_y_o,
  output logic [DW-1:0] trip_cb_o,
  output logic [DW-1:0] trip_cr_o,
  output logic          solo_valid_o,
  output logic [DW-1:0] solo_y_o
);
  localparam int LANES = 2;

  logic [DW-1:0] hold [LANES];

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) hold[g] <= '0;
      else if (live_i && phase_i == phase_t'(PH_W'(g))) hold[g] <= word_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      trip_valid_o <= 1'b0;
      solo_valid_o <= 1'b0;
      trip_y_o     <= '0;
      trip_cb_o    <= '0;
      trip_cr_o    <= '0;
      solo_y_o     <= '0;
    end else begin
      trip_valid_o <= 1'b0;
      solo_valid_o <= 1'b0;
      if (live_i) begin
        case (phase_i)
          PH_CR: begin
            trip_valid_o <= 1'b1;
            trip_cb_o    <= hold[0];
            trip_y_o     <= hold[1];
            trip_cr_o    <= word_i;
          end
          PH_Y1: begin
            solo_valid_o <= 1'b1;
            solo_y_o     <= word_i;
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/vdmx.sv
module vdmx
  import vdmx_pkg::*;
#(
  parameter int DATA_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sync_i,
  input  logic [DATA_W-1:0] word_i,
  output logic              trip_valid_o,
  output logic [DATA_W-1:0] trip_y_o,
  output logic [DATA_W-1:0] trip_cb_o,
  output logic [DATA_W-1:0] trip_cr_o,
  output logic              solo_valid_o,
  output logic [DATA_W-1:0] solo_y_o
);
  phase_t phase;
  logic   live;

  vdmx_phase u_phase (
    .clk     (clk),
    .rst_n   (rst_n),
    .sync_i  (sync_i),
    .phase_o (phase),
    .live_o  (live)
  );

  vdmx_capture #(.DW(DATA_W)) u_capture (
    .clk          (clk),
    .rst_n        (rst_n),
    .phase_i      (phase),
    .live_i       (live),
    .word_i       (word_i),
    .trip_valid_o (trip_valid_o),
    .trip_y_o     (trip_y_o),
    .trip_cb_o    (trip_cb_o),
    .trip_cr_o    (trip_cr_o),
    .solo_valid_o (solo_valid_o),
    .solo_y_o     (solo_y_o)
  );
endmodule

// File: rtl/vdmx_chk.sv
module vdmx_chk #(
  parameter int DW = 10
) (
  input logic          clk,
  input logic          rst_n,
  input logic          sync_i,
  input logic          trip_valid_o,
  input logic [DW-1:0] trip_y_o,
  input logic [DW-1:0] trip_cb_o,
  input logic [DW-1:0] trip_cr_o,
  input logic          solo_valid_o,
  input logic [DW-1:0] solo_y_o
);
  logic       sync_d;
  logic       seen_q;
  logic [2:0] age_q;
  logic       ev;

  assign ev = sync_d & ~sync_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_d <= 1'b0;
      seen_q <= 1'b0;
      age_q  <= '0;
    end else begin
      sync_d <= sync_i;
      if (ev) seen_q <= 1'b1;
      if (ev) age_q <= 3'd1;
      else if (age_q != 3'd0 && age_q < 3'd4) age_q <= age_q + 3'd1;
      else age_q <= 3'd0;
    end
  end

  // R2
  no_early_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !seen_q |-> (!trip_valid_o && !solo_valid_o));

  // R3
  triple_after_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (age_q == 3'd3) |-> trip_valid_o);

  // R4
  triple_one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    trip_valid_o |=> !trip_valid_o);

  // R5
  solo_follows_triple_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (trip_valid_o && !ev) |=> solo_valid_o);

  // R10
  strobes_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(trip_valid_o && solo_valid_o));

  // R11
  triple_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !trip_valid_o |-> ($stable(trip_y_o) && $stable(trip_cb_o) && $stable(trip_cr_o)));

  // R11
  solo_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !solo_valid_o |-> $stable(solo_y_o));
endmodule

bind vdmx vdmx_chk #(.DW(DATA_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .sync_i       (sync_i),
  .trip_valid_o (trip_valid_o),
  .trip_y_o     (trip_y_o),
  .trip_cb_o    (trip_cb_o),
  .trip_cr_o    (trip_cr_o),
  .solo_valid_o (solo_valid_o),
  .solo_y_o     (solo_y_o)
);

// File: tb/vdmx_tb.sv
module vdmx_tb;
  localparam int DW = 10;
  localparam int NV = 13;
  // {sync, word, exp_trip, exp_solo, exp_y, exp_cb, exp_cr, exp_solo_y}
  localparam logic [52:0] VEC [NV] = '{
    {1'b1, 10'h111, 1'b0, 1'b0, 10'h000, 10'h000, 10'h000, 10'h000},
    {1'b0, 10'h040, 1'b0, 1'b0, 10'h000, 10'h000, 10'h000, 10'h000},
    {1'b0, 10'h3FF, 1'b0, 1'b0, 10'h000, 10'h000, 10'h000, 10'h000},
    {1'b0, 10'h200, 1'b1, 1'b0, 10'h3FF, 10'h040, 10'h200, 10'h000},
    {1'b0, 10'h000, 1'b0, 1'b1, 10'h000, 10'h000, 10'h000, 10'h000},
    {1'b0, 10'h2A8, 1'b0, 1'b0, 10'h000, 10'h000, 10'h000, 10'h000},
    {1'b0, 10'h155, 1'b0, 1'b0, 10'h000, 10'h000, 10'h000, 10'h000},
    {1'b0, 10'h0FC, 1'b1, 1'b0, 10'h155, 10'h2A8, 10'h0FC, 10'h000},
    {1'b1, 10'h3AC, 1'b0, 1'b1, 10'h000, 10'h000, 10'h000, 10'h3AC},
    {1'b0, 10'h123, 1'b0, 1'b0, 10'h000, 10'h000, 10'h000, 10'h000},
    {1'b0, 10'h0AB, 1'b0, 1'b0, 10'h000, 10'h000, 10'h000, 10'h000},
    {1'b0, 10'h321, 1'b1, 1'b0, 10'h0AB, 10'h123, 10'h321, 10'h000},
    {1'b1, 10'h00F, 1'b0, 1'b1, 10'h000, 10'h000, 10'h000, 10'h00F}
  };

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          sync_i = 1'b0;
  logic [DW-1:0] word_i = '0;
  logic          trip_valid_o, solo_valid_o;
  logic [DW-1:0] trip_y_o, trip_cb_o, trip_cr_o, solo_y_o;

  int errors = 0;
  int checks = 0;

  always #10 clk = ~clk;

  vdmx #(.DATA_W(DW)) u_dut (
    .clk(clk), .rst_n(rst_n), .sync_i(sync_i), .word_i(word_i),
    .trip_valid_o(trip_valid_o), .trip_y_o(trip_y_o), .trip_cb_o(trip_cb_o),
    .trip_cr_o(trip_cr_o), .solo_valid_o(solo_valid_o), .solo_y_o(solo_y_o)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step(input logic s, input logic [DW-1:0] w);
    sync_i = s;
    word_i = w;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic no_strobe(input string req);
    check(req, {30'd0, trip_valid_o, solo_valid_o}, 32'd0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    @(negedge clk);
    @(negedge clk);
    // R1: outputs cleared in reset
    no_strobe("R1 strobes");
    check("R1 data", {2'b0, trip_y_o, trip_cb_o, trip_cr_o}, 32'd0);
    check("R1 solo", {22'd0, solo_y_o}, 32'd0);
    rst_n = 1'b1;

    // R2: no alignment without a high-then-low pulse
    for (int i = 0; i < 8; i++) begin
      step(1'b0, DW'(i + 5));
      no_strobe("R2 sync low");
    end
    for (int i = 0; i < 3; i++) begin
      step(1'b1, DW'(i + 9));
      no_strobe("R2 sync high");
    end

    // Table: R3 alignment, R4 triple, R5 solo, R7 per-group pulse, R9 values
    for (int i = 0; i < NV; i++) begin
      step(VEC[i][52], VEC[i][51:42]);
      check("R4 trip strobe", {31'd0, trip_valid_o}, {31'd0, VEC[i][41]});
      check("R5 solo strobe", {31'd0, solo_valid_o}, {31'd0, VEC[i][40]});
      if (VEC[i][41]) begin
        check("R3 R9 trip_y", {22'd0, trip_y_o}, {22'd0, VEC[i][39:30]});
        check("R3 R9 trip_cb", {22'd0, trip_cb_o}, {22'd0, VEC[i][29:20]});
        check("R3 R9 trip_cr", {22'd0, trip_cr_o}, {22'd0, VEC[i][19:10]});
      end
      if (VEC[i][40])
        check("R7 R9 solo_y", {22'd0, solo_y_o}, {22'd0, VEC[i][9:0]});
    end

    // R8: re-align on a Cr-phase word; the interrupted triple is dropped
    step(1'b0, 10'h050);
    no_strobe("R8 cb");
    step(1'b1, 10'h060);
    no_strobe("R8 y");
    step(1'b0, 10'h070);
    check("R8 dropped triple", {31'd0, trip_valid_o}, 32'd0);
    step(1'b0, 10'h080);
    no_strobe("R8 new y");
    step(1'b0, 10'h090);
    check("R8 new trip", {31'd0, trip_valid_o}, 32'd1);
    check("R8 new cb", {22'd0, trip_cb_o}, 32'h070);
    check("R8 new y", {22'd0, trip_y_o}, 32'h080);
    check("R8 new cr", {22'd0, trip_cr_o}, 32'h090);
    step(1'b0, 10'h0A0);
    check("R8 solo", {31'd0, solo_valid_o}, 32'd1);
    check("R8 solo_y", {22'd0, solo_y_o}, 32'h0A0);

    // R6: free run with sync low, phase continues from Cb
    for (int i = 0; i < 40; i++) begin
      step(1'b0, DW'(10'h100 + i));
      check("R6 trip", {31'd0, trip_valid_o}, {31'd0, (i % 4) == 2});
      check("R6 solo", {31'd0, solo_valid_o}, {31'd0, (i % 4) == 3});
      if ((i % 4) == 2)
        check("R6 cb", {22'd0, trip_cb_o}, 32'h100 + 32'(i - 2));
      if ((i % 4) == 3)
        check("R6 solo_y", {22'd0, solo_y_o}, 32'h100 + 32'(i));
    end

    // R1 and R2 again: reset mid-stream loses alignment
    rst_n = 1'b0;
    @(negedge clk);
    no_strobe("R1 mid reset");
    check("R1 mid data", {2'b0, trip_y_o, trip_cb_o, trip_cr_o}, 32'd0);
    rst_n = 1'b1;
    for (int i = 0; i < 8; i++) begin
      step(1'b0, DW'(i));
      no_strobe("R2 after reset");
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule